// File: doc/BRIEF.md
# Cascaded Fall-Through FIFO Chain

This block builds a deep first-in first-out buffer from a row of identical shallow fall-through stages. A word presented to the first stage ripples from stage to stage without any read request, and it appears at the output of the last stage. When room opens at the tail of a full chain, the free slot moves back toward the head one stage at a time.

Each stage has two active-low flags. The output-ready flag goes low when the stage holds a word that its reader can see. The input-ready flag goes low when the stage has a free slot. Between neighbours, the upstream output-ready flag is the downstream write enable, and the downstream input-ready flag is the upstream read enable. A word moves across a link on any edge where both flags of that link are low. No other glue logic sits between the stages.

All stages run on one clock. That clock stands for the transfer clock, which is tied to the faster of the write and read clocks. At the block edge the interface has four parts: a write enable with data and input-ready on the first stage, and a read enable with data and output-ready on the last stage. Each stage has a fixed internal flag latency. A write becomes visible to the stage's reader after three edges, and a read returns credit to the stage's writer after two edges.

Top module: `fifo_chain`

## Requirements
- R1: While reset is held and directly after it, `inRdyN` is 0 (space available) and `outRdyN` is 1 (no data).
- R2: With no reads, the chain accepts exactly `N_STAGES*STAGE_DEPTH` writes, and `inRdyN` then stays 1.
- R3: Words leave in the order they were accepted, with none lost or duplicated. While `outRdyN` is 0 and `rdEnN` is 1, `rdData` and `outRdyN` hold their values.
- R4: A cycle with `wrEnN`=0 while `inRdyN`=1 stores nothing: the attempted word never appears at the output and does not add to the accepted count.
- R5: A cycle with `rdEnN`=0 while `outRdyN`=1 removes nothing: a word written afterwards is still the first one delivered.
- R6: On an empty chain with no reads, `outRdyN` goes low exactly `4*(N_STAGES-1)+3` edges after the edge that accepted the first write.
- R7: On a full chain, `inRdyN` goes low exactly `3*(N_STAGES-1)+2` edges after the edge that accepted a single read at the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transfer clock shared by all stages |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEnN | input | 1 | Active-low write request into the first stage |
| wrData | input | DATA_W | Word to write |
| inRdyN | output | 1 | Active-low: first stage can accept a word |
| rdEnN | input | 1 | Active-low read request from the last stage |
| rdData | output | DATA_W | Head word of the chain, valid while outRdyN is 0 |
| outRdyN | output | 1 | Active-low: last stage presents a valid word |

## Verification
The bench builds the chain with three stages of depth four and 8-bit words. The total capacity is then twelve words, so filling the chain and watching `inRdyN` stay high takes only a few dozen cycles. With three stages, a word crosses two internal links. The expected latencies are therefore 11 edges for the ripple and 8 edges for the bubble, so a change to any per-stage delay or to the link handshake alters the count the bench measures. A long random phase with independent write and read requests then runs the stages through partly full states, where words and free slots move in both directions at once.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;
  // Edges from an accepted write until the stage's reader sees the word.
  localparam int FALL_LAT   = 3;
  // Edges from an accepted read until the stage's writer regains the slot.
  localparam int BUBBLE_LAT = 2;

  typedef struct packed {
    logic push;
    logic pop;
  } stageStrobe_t;
endpackage

// File: rtl/stage_ctrl.sv
module stage_ctrl
  import fifo_chain_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEnN,
  input  logic         rdEnN,
  output logic         inRdyN,
  output logic         outRdyN,
  output stageStrobe_t strobe
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]      wrCount, rdCount, wrCountNext, rdCountNext;
  logic [FALL_LAT-1:0]   pushPipe;
  logic [BUBBLE_LAT-1:0] popPipe;
  logic                  push, pop;

  assign push = !wrEnN && !inRdyN;
  assign pop  = !rdEnN && !outRdyN;
  assign strobe.push = push;
  assign strobe.pop  = pop;

  // Writer view: writes count at once, reads are credited late (conservative).
  assign wrCountNext = wrCount + CNT_W'(push) - CNT_W'(popPipe[BUBBLE_LAT-1]);
  // Reader view: reads count at once, writes become visible late (conservative).
  assign rdCountNext = rdCount + CNT_W'(pushPipe[FALL_LAT-1]) - CNT_W'(pop);

  generate
    if (FALL_LAT > 1) begin : g_pushShift
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) pushPipe <= '0;
        else       pushPipe <= {pushPipe[FALL_LAT-2:0], push};
    end else begin : g_pushOne
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) pushPipe <= '0;
        else       pushPipe <= push;
    end
    if (BUBBLE_LAT > 1) begin : g_popShift
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) popPipe <= '0;
        else       popPipe <= {popPipe[BUBBLE_LAT-2:0], pop};
    end else begin : g_popOne
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) popPipe <= '0;
        else       popPipe <= pop;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrCount <= '0;
      rdCount <= '0;
      inRdyN  <= 1'b0;
      outRdyN <= 1'b1;
    end else begin
      wrCount <= wrCountNext;
      rdCount <= rdCountNext;
      inRdyN  <= (wrCountNext == CNT_W'(DEPTH));
      outRdyN <= (rdCountNext == '0);
    end
  end

  // R3: with no pop, the reader's view can only grow, so valid data stays valid
  a_r3_valid_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!outRdyN && rdEnN) |=> !outRdyN);
endmodule

// File: rtl/stage_dpath.sv
module stage_dpath
  import fifo_chain_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  stageStrobe_t      strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fill;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk)
    if (strobe.push) mem[wrPtr] <= wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (strobe.push) wrPtr <= bump(wrPtr);
      if (strobe.pop)  rdPtr <= bump(rdPtr);
      fill <= fill + CNT_W'(strobe.push) - CNT_W'(strobe.pop);
    end
  end

  // Fall-through: the head slot is always on the output.
  assign rdData = mem[rdPtr];

  // R4: the control never writes into a stage that is really full
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> (fill != CNT_W'(DEPTH)));
  // R5: the control never pops a stage that is really empty
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> (fill != '0));
  // R3: an empty stage has both pointers on the same slot
  a_r3_pointer_gap: assert property (@(posedge clk) disable iff (!rstN)
    (fill == '0) |-> (wrPtr == rdPtr));
endmodule

// File: rtl/fifo_stage.sv
module fifo_stage
  import fifo_chain_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEnN,
  input  logic [DATA_W-1:0] wrData,
  output logic              inRdyN,
  input  logic              rdEnN,
  output logic [DATA_W-1:0] rdData,
  output logic              outRdyN
);
  stageStrobe_t strobe;

  stage_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEnN(wrEnN), .rdEnN(rdEnN),
    .inRdyN(inRdyN), .outRdyN(outRdyN), .strobe(strobe)
  );

  stage_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/fifo_chain.sv
module fifo_chain #(
  parameter int DATA_W      = 8,
  parameter int STAGE_DEPTH = 4,
  parameter int N_STAGES    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEnN,
  input  logic [DATA_W-1:0] wrData,
  output logic              inRdyN,
  input  logic              rdEnN,
  output logic [DATA_W-1:0] rdData,
  output logic              outRdyN
);
  logic [DATA_W-1:0] stgIn   [N_STAGES];
  logic [DATA_W-1:0] stgOut  [N_STAGES];
  logic              stgWrN  [N_STAGES];
  logic              stgRdN  [N_STAGES];
  logic              stgInR  [N_STAGES];
  logic              stgOutR [N_STAGES];

  genvar k;
  generate
    for (k = 0; k < N_STAGES; k++) begin : g_stage
      if (k == 0) begin : g_head
        assign stgWrN[k] = wrEnN;
        assign stgIn[k]  = wrData;
      end else begin : g_link
        // Upstream output-ready is this stage's write enable.
        assign stgWrN[k] = stgOutR[k-1];
        assign stgIn[k]  = stgOut[k-1];
      end
      if (k == N_STAGES - 1) begin : g_tail
        assign stgRdN[k] = rdEnN;
      end else begin : g_back
        // Downstream input-ready is this stage's read enable.
        assign stgRdN[k] = stgInR[k+1];
      end

      fifo_stage #(.DATA_W(DATA_W), .DEPTH(STAGE_DEPTH)) u_stage (
        .clk(clk), .rstN(rstN),
        .wrEnN(stgWrN[k]), .wrData(stgIn[k]), .inRdyN(stgInR[k]),
        .rdEnN(stgRdN[k]), .rdData(stgOut[k]), .outRdyN(stgOutR[k])
      );
    end
  endgenerate

  assign inRdyN  = stgInR[0];
  assign rdData  = stgOut[N_STAGES-1];
  assign outRdyN = stgOutR[N_STAGES-1];

  // R3: the head word is held while the reader waits
  a_r3_hold_head: assert property (@(posedge clk) disable iff (!rstN)
    (!outRdyN && rdEnN) |=> $stable(rdData));
endmodule

// File: tb/fifo_chain_bench.sv
`timescale 1ns/1ps
module fifo_chain_bench;
  localparam int DW = 8;
  localparam int D  = 4;
  localparam int N  = 3;
  localparam int CAP = N * D;
  localparam int RIPPLE = 4 * (N - 1) + 3;
  localparam int BUBBLE = 3 * (N - 1) + 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEnN = 1'b1;
  logic [DW-1:0] wrData = '0;
  logic          rdEnN = 1'b1;
  logic [DW-1:0] rdData;
  logic          inRdyN, outRdyN;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  int nWr     = 0;
  int nRd     = 0;
  logic [DW-1:0] expQ [$];
  logic [DW-1:0] seqVal = 8'h10;

  always #2.5 clk = ~clk;

  fifo_chain #(.DATA_W(DW), .STAGE_DEPTH(D), .N_STAGES(N)) u_fifo_chain (
    .clk(clk), .rstN(rstN), .wrEnN(wrEnN), .wrData(wrData), .inRdyN(inRdyN),
    .rdEnN(rdEnN), .rdData(rdData), .outRdyN(outRdyN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver side: applies inputs and records accepted words.
  task automatic drive(input bit doWr, input logic [DW-1:0] d, input bit doRd);
    @(negedge clk);
    wrEnN = !doWr; wrData = d; rdEnN = !doRd;
    #1;
    cyc++;
    if (!wrEnN && !inRdyN) begin
      expQ.push_back(d);
      nWr++;
    end
  endtask

  // Monitor side: compares the word leaving on the coming edge.
  task automatic monitor();
    logic [DW-1:0] e;
    if (!rdEnN && !outRdyN) begin
      nRd++;
      if (expQ.size() == 0) check(1'b0, "R3 read with empty model", int'(rdData), -1);
      else begin
        e = expQ.pop_front();
        check(rdData == e, "R3 order", int'(rdData), int'(e));
      end
    end
  endtask

  task automatic step(input bit doWr, input logic [DW-1:0] d, input bit doRd);
    drive(doWr, d, doRd);
    monitor();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int k, lat, base;
    // R1: flags during and after reset
    #7;
    check(inRdyN == 1'b0, "R1 inRdyN in reset", int'(inRdyN), 0);
    check(outRdyN == 1'b1, "R1 outRdyN in reset", int'(outRdyN), 1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(0, 0, 0);
    check(inRdyN == 1'b0, "R1 inRdyN after reset", int'(inRdyN), 0);
    check(outRdyN == 1'b1, "R1 outRdyN after reset", int'(outRdyN), 1);

    // R5: reads on an empty chain are ignored
    for (int i = 0; i < 6; i++) begin
      step(0, 0, 1);
      check(outRdyN == 1'b1, "R5 empty read", int'(outRdyN), 1);
    end
    check(nRd == 0, "R5 no read accepted", nRd, 0);

    // R6: ripple latency of the first word, no read request
    step(1, 8'hA5, 0);
    k = cyc;
    lat = -1;
    for (int i = 0; i < 40; i++) begin
      step(0, 0, 0);
      if (!outRdyN) begin lat = cyc - k - 1; break; end
    end
    check(lat == RIPPLE, "R6 ripple latency", lat, RIPPLE);
    check(rdData == 8'hA5, "R5 first word kept", int'(rdData), 8'hA5);
    // R3: head held while not read
    step(0, 0, 0);
    check(rdData == 8'hA5 && !outRdyN, "R3 head held", int'(rdData), 8'hA5);
    step(0, 0, 1);
    for (int i = 0; i < 10; i++) step(0, 0, 0);
    check(outRdyN == 1'b1, "R3 empty after single read", int'(outRdyN), 1);

    // R2 and R4: fill with writes every cycle, no reads
    base = nWr;
    for (int i = 0; i < 120; i++) begin
      step(1, seqVal, 0);
      seqVal++;
    end
    check(nWr - base == CAP, "R2 capacity", nWr - base, CAP);
    check(inRdyN == 1'b1, "R4 full flag high", int'(inRdyN), 1);
    check(expQ.size() == CAP, "R4 ignored writes not stored", expQ.size(), CAP);

    // R7: bubble latency of a single read from a full chain
    step(0, 0, 1);
    k = cyc;
    lat = -1;
    for (int i = 0; i < 40; i++) begin
      step(0, 0, 0);
      if (!inRdyN) begin lat = cyc - k - 1; break; end
    end
    check(lat == BUBBLE, "R7 bubble latency", lat, BUBBLE);

    // R3: drain in order
    for (int i = 0; i < 80; i++) step(0, 0, 1);
    check(expQ.size() == 0, "R3 drained", expQ.size(), 0);
    check(outRdyN == 1'b1, "R3 empty after drain", int'(outRdyN), 1);

    // R3/R4/R5: mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 3) != 0, seqVal, ($urandom % 2) != 0);
      seqVal++;
    end
    for (int i = 0; i < 100; i++) step(0, 0, 1);
    check(expQ.size() == 0, "R3 random drained", expQ.size(), 0);
    check(nRd == nWr, "R3 counts match", nRd, nWr);

    summary();
    $finish;
  end
endmodule